// File: doc/BRIEF.md
# PME Group Wake Aggregator

This block merges several active-low wake request groups, one per PCI bus segment, into one active-low wake line. That line feeds a single edge-triggered general purpose event input of the power management logic. Each group has its own input. The block treats only a falling edge on a group as an event. A group that stays low after its edge adds nothing further. Because of this, a device whose wake request is still asserted cannot cause endless event retriggering while software works on clearing it.

Every group input passes through a two-flop synchronizer before edge detection. A falling edge sets that group's sticky status bit. Software reads and clears the status bits through a small register port. If the group's enable bit is set, the edge also produces one low pulse on the shared output. The pulse width is a fixed number of clocks derived from the clock frequency and a target time in microseconds. Edges that arrive while a pulse or its recovery gap is running are folded into one extra pulse. That extra pulse is issued after the line has been high for a full pulse width, so the downstream edge detector sees a clean new edge.

Top module: `pme_wake_agg`

## Requirements
- R1: After reset the wake output is high, every status bit reads 0 and every enable bit reads 0.
- R2: A falling edge on group input i sets status bit i. Status is read with register address 0, and bit i belongs to group i. The bit is set on the second clock edge after the input is sampled low.
- R3: A group input that stays low after its falling edge produces no further event. A rising edge on a group input produces no event.
- R4: Writing to address 0 clears each status bit whose written data bit is 1 and leaves the other bits unchanged. If a new falling edge on a group coincides with a clear of that group's bit, the bit ends up set.
- R5: A falling edge on an enabled group drives the wake output low on the second clock edge after the input is sampled low. The output stays low for exactly PULSE_CYC = CLK_MHZ*PULSE_US cycles, with PULSE_US between 10 and 100.
- R6: A falling edge on a group whose enable bit is 0 sets its status bit but produces no pulse.
- R7: Enabled edges that arrive during a pulse or during its recovery gap produce exactly one further pulse, however many such edges there are. That pulse starts after the output has been high for PULSE_CYC cycles.
- R8: Writing to address 1 loads the per-group enable bits. Reading address 1 returns them, with bit i enabling group i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grp_pme_n_i | input | N_GRP | Active-low wake request, one bit per group, asynchronous |
| wake_n_o | output | 1 | Active-low wake pulse to the general purpose event input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | N_GRP | Write data |
| reg_rdata_o | output | N_GRP | Read data for the selected register (combinational) |

## Verification
An input that is low at clock edge k shows up in the status register and on the wake output after edge k+2. The output rises again after edge k+2+PULSE_CYC. A queued second pulse falls after edge k+2+2*PULSE_CYC. The bench drives inputs just after a falling clock edge and samples shortly after later falling edges, so each check lands in the cycle the count above predicts. A monitor runs on the falling edge and records the count of pulses and the length of each low and high run. Checks that depend on settled counts wait well past the gap interval before reading them.

// File: rtl/pme_agg_pkg.sv
package pme_agg_pkg;
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOW  = 2'd1,
        PG_GAP  = 2'd2
    } pg_state_e;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/pme_edge_sync.sv
module pme_edge_sync #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_n_i,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } es_t;

    es_t es_d, es_q;

    always_comb begin
        es_d      = es_q;
        es_d.meta = pin_n_i;
        es_d.sync = es_q.meta;
        es_d.prev = es_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) es_q <= '{meta: '1, sync: '1, prev: '1};
        else         es_q <= es_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_grp
        assign fall_o[g] = es_q.prev[g] & ~es_q.sync[g];
    end
endmodule

// File: rtl/pme_grp_regs.sv
module pme_grp_regs #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] fall_i,
    input  logic         wr_i,
    input  logic         addr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] enable_o
);
    import pme_agg_pkg::*;

    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] enable;
    } gr_t;

    gr_t gr_d, gr_q;

    always_comb begin
        logic [N-1:0] clr;
        gr_d = gr_q;
        clr  = (wr_i && addr_i == ADDR_STATUS) ? wdata_i : '0;
        // a fresh edge outranks a simultaneous write-one-to-clear
        gr_d.status = (gr_q.status & ~clr) | fall_i;
        if (wr_i && addr_i == ADDR_ENABLE) gr_d.enable = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gr_q <= '0;
        else         gr_q <= gr_d;
    end

    assign status_o = gr_q.status;
    assign enable_o = gr_q.enable;
endmodule

// File: rtl/pme_pulse_gen.sv
module pme_pulse_gen #(
    parameter int PULSE_CYC = 2500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic wake_n_o
);
    import pme_agg_pkg::*;

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        pg_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic           pend;
        logic           wake_n;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        unique case (pg_q.state)
            PG_IDLE: begin
                if (req_i) begin
                    pg_d.state  = PG_LOW;
                    pg_d.cnt    = '0;
                    pg_d.wake_n = 1'b0;
                end
            end
            PG_LOW: begin
                if (req_i) pg_d.pend = 1'b1;
                if (pg_q.cnt == LAST) begin
                    pg_d.state  = PG_GAP;
                    pg_d.cnt    = '0;
                    pg_d.wake_n = 1'b1;
                end else begin
                    pg_d.cnt = pg_q.cnt + CNT_W'(1);
                end
            end
            PG_GAP: begin
                if (pg_q.cnt == LAST) begin
                    pg_d.cnt  = '0;
                    pg_d.pend = 1'b0;
                    if (pg_q.pend || req_i) begin
                        pg_d.state  = PG_LOW;
                        pg_d.wake_n = 1'b0;
                    end else begin
                        pg_d.state = PG_IDLE;
                    end
                end else begin
                    pg_d.cnt = pg_q.cnt + CNT_W'(1);
                    if (req_i) pg_d.pend = 1'b1;
                end
            end
            default: pg_d = '{state: PG_IDLE, cnt: '0, pend: 1'b0, wake_n: 1'b1};
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pg_q <= '{state: PG_IDLE, cnt: '0, pend: 1'b0, wake_n: 1'b1};
        else         pg_q <= pg_d;
    end

    assign wake_n_o = pg_q.wake_n;
endmodule

// File: rtl/pme_wake_agg.sv
module pme_wake_agg #(
    parameter int N_GRP    = 4,
    parameter int CLK_MHZ  = 50,
    parameter int PULSE_US = 50
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_GRP-1:0] grp_pme_n_i,
    output logic             wake_n_o,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [N_GRP-1:0] reg_wdata_i,
    output logic [N_GRP-1:0] reg_rdata_o
);
    import pme_agg_pkg::*;

    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;

    logic [N_GRP-1:0] grp_fall;
    logic [N_GRP-1:0] grp_status;
    logic [N_GRP-1:0] grp_enable;

    pme_edge_sync #(.N(N_GRP)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_n_i (grp_pme_n_i),
        .fall_o  (grp_fall)
    );

    pme_grp_regs #(.N(N_GRP)) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fall_i   (grp_fall),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .status_o (grp_status),
        .enable_o (grp_enable)
    );

    pme_pulse_gen #(.PULSE_CYC(PULSE_CYC)) i_pulse (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (|(grp_fall & grp_enable)),
        .wake_n_o (wake_n_o)
    );

    assign reg_rdata_o = (reg_addr_i == ADDR_ENABLE) ? grp_enable : grp_status;
endmodule

// File: rtl/pme_wake_agg_chk.sv
module pme_wake_agg_chk #(
    parameter int N         = 4,
    parameter int PULSE_CYC = 2500
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         wake_n,
    input logic [N-1:0] fall,
    input logic [N-1:0] status,
    input logic         reg_wr,
    input logic         reg_addr
);
    logic [31:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_cnt <= '0;
            hi_cnt <= 32'(PULSE_CYC);
        end else begin
            lo_cnt <= wake_n ? '0 : lo_cnt + 32'd1;
            if (!wake_n)                       hi_cnt <= '0;
            else if (hi_cnt < 32'(PULSE_CYC))  hi_cnt <= hi_cnt + 32'd1;
        end
    end

    AST_LOW_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wake_n) |-> lo_cnt == 32'(PULSE_CYC));  // R5
    AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wake_n |-> lo_cnt < 32'(PULSE_CYC));  // R5
    AST_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wake_n) |-> hi_cnt >= 32'(PULSE_CYC));  // R7
    AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|fall) |=> ((status & $past(fall)) == $past(fall)));  // R2
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_wr && reg_addr == 1'b0) |=> ((status & $past(status)) == $past(status)));  // R4
endmodule

bind pme_wake_agg pme_wake_agg_chk #(.N(N_GRP), .PULSE_CYC(CLK_MHZ * PULSE_US)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_n   (wake_n_o),
    .fall     (grp_fall),
    .status   (grp_status),
    .reg_wr   (reg_wr_i),
    .reg_addr (reg_addr_i)
);

// File: tb/test_pme_wake_agg.sv
module test_pme_wake_agg;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int P = 20;  // CLK_MHZ 1 * PULSE_US 20

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] grp_n = '1;
    logic         wake_n;
    logic         reg_wr = 1'b0;
    logic         reg_addr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pme_wake_agg #(.N_GRP(N), .CLK_MHZ(1), .PULSE_US(P)) i_pme_wake_agg (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .grp_pme_n_i (grp_n),
        .wake_n_o    (wake_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata)
    );

    // pulse monitor, independent of the design
    int n_pulse = 0, lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
    logic mon_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!wake_n) begin
                if (mon_prev) begin n_pulse++; last_hi = hi_run; lo_run = 0; end
                lo_run++;
            end else begin
                if (!mon_prev) begin last_lo = lo_run; hi_run = 0; end
                hi_run++;
            end
            mon_prev = wake_n;
        end
    end

    typedef struct packed {
        logic [3:0] en;
        logic [3:0] mask;
        logic [3:0] exp_st;
        logic [3:0] exp_p;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{en: 4'hF, mask: 4'h1, exp_st: 4'h1, exp_p: 4'd1},
        '{en: 4'hF, mask: 4'hA, exp_st: 4'hA, exp_p: 4'd1},
        '{en: 4'h0, mask: 4'h4, exp_st: 4'h4, exp_p: 4'd0},
        '{en: 4'h2, mask: 4'h5, exp_st: 4'h5, exp_p: 4'd0},
        '{en: 4'h8, mask: 4'hF, exp_st: 4'hF, exp_p: 4'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        waitc(1);
        chk("R1 wake high", int'(wake_n), 1);
        rd(1'b0, v); chk("R1 status clear", int'(v), 0);
        rd(1'b1, v); chk("R1 enable clear", int'(v), 0);

        wr(1'b1, 4'h5);
        rd(1'b1, v); chk("R8 enable readback", int'(v), 5);

        // R5 exact timing of one pulse
        wr(1'b1, 4'h1);
        waitc(1);
        base = n_pulse;
        grp_n[0] = 1'b0;              // low before edge k
        waitc(1); chk("R5 high after k", int'(wake_n), 1);
        waitc(1); chk("R5 high after k+1", int'(wake_n), 1);
        waitc(1); chk("R5 low after k+2", int'(wake_n), 0);
        rd(1'b0, v); chk("R2 status bit0 set", int'(v), 1);
        waitc(P-1); chk("R5 still low at end", int'(wake_n), 0);
        waitc(1); chk("R5 high after P cycles", int'(wake_n), 1);
        waitc(2); chk("R5 low width", last_lo, P);
        // R3 held low gives no more events
        waitc(3*P);
        chk("R3 held low single pulse", n_pulse - base, 1);
        grp_n[0] = 1'b1;
        waitc(8);
        chk("R3 rising edge no pulse", n_pulse - base, 1);

        // table of vectors
        foreach (VECS[i]) begin
            grp_n = '1;
            waitc(2*P + 8);
            wr(1'b1, VECS[i].en);
            wr(1'b0, 4'hF);
            base = n_pulse;
            grp_n = ~VECS[i].mask;
            waitc(3*P + 8);
            rd(1'b0, v);
            chk("R2/R6 vector status", int'(v), int'(VECS[i].exp_st));
            chk("R5/R6 vector pulses", n_pulse - base, int'(VECS[i].exp_p));
            grp_n = '1;
            waitc(6);
            chk("R3 vector release", n_pulse - base, int'(VECS[i].exp_p));
            rd(1'b0, v);
            chk("R2 vector status kept", int'(v), int'(VECS[i].exp_st));
        end

        // R7 edges during a pulse fold into one extra pulse
        waitc(2*P + 8);
        wr(1'b1, 4'hF);
        wr(1'b0, 4'hF);
        base = n_pulse;
        grp_n[0] = 1'b0;
        waitc(6);  grp_n[1] = 1'b0;
        waitc(2);  grp_n[2] = 1'b0;
        waitc(4*P + 10);
        chk("R7 two pulses", n_pulse - base, 2);
        chk("R7 gap width", last_hi, P);
        chk("R7 second low width", last_lo, P);
        rd(1'b0, v); chk("R7 status", int'(v), 7);
        grp_n = '1;

        // R4 write-one-to-clear and collision with a new edge
        waitc(2*P + 8);
        wr(1'b1, 4'h0);
        wr(1'b0, 4'hF);
        grp_n[0] = 1'b0;
        waitc(4);
        rd(1'b0, v); chk("R6 disabled status", int'(v), 1);
        grp_n[3] = 1'b0;              // low before edge k
        waitc(1);                     // after edge k
        wr(1'b0, 4'b1001);            // write sampled at edge k+2
        rd(1'b0, v); chk("R4 clear vs new edge", int'(v), 8);
        wr(1'b0, 4'h0);
        rd(1'b0, v); chk("R4 zero write keeps", int'(v), 8);
        wr(1'b0, 4'h8);
        rd(1'b0, v); chk("R4 clear bit3", int'(v), 0);
        chk("R6 no pulse while disabled", int'(wake_n), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule